// File: doc/BRIEF.md
# Run-length sample packetizer

This block takes a stream of 16-bit logic samples, one per asserted sample enable, and folds consecutive equal samples into run-length records. Each record is serialized as three bytes and pushed out on a byte-wide stream with a valid/ready handshake, ready to be moved by a bulk transport. Records are collected into groups of a fixed size, and every group is closed by a sequence byte, so that a receiver can detect lost or reordered groups.

A trigger marker that arrives with a sample forces that sample to open a new record. The block then reports how many records were emitted before the trigger, so that the host can locate the trigger in the decompressed stream by counting records. When the capture ends, the open run is flushed and the last group is completed with filler records. A small record FIFO decouples sample arrival from output backpressure. Storage, the transport itself and trigger detection are done elsewhere.

Top module: `rle_packetizer`

## Requirements
- R1: Each record is three bytes on the output in this order: sample bits [7:0], sample bits [15:8], then the 8-bit repeat count.
- R2: Consecutive enabled samples with equal value are merged into one record whose count equals the number of samples. A change of value starts a new record.
- R3: The count is 1 to 255 and is never 0. A run of more than 255 equal samples is split, for example 256 gives counts 255 and 1, and 520 gives 255, 255 and 10.
- R4: A sample that arrives with the trigger marker always starts a new record, even if its value equals the open run. At the first trigger after reset, the number of records completed before that sample appears on the pretrigger count output and its valid flag rises. Both then stay fixed until reset, and later triggers do not change them.
- R5: After every RECS_PER_GRP records one sequence byte is output. The sequence byte is 0 for the first group after reset and increments modulo 256 per group.
- R6: When the capture ends, the open run is flushed as a record. The last group is then padded with records of count 1 that carry the final record's value, until the group is complete. If no sample was taken, nothing is output. The drained flag rises once every byte has been accepted, and it stays high until reset.
- R7: While the byte valid is high and ready is low, valid stays high and the byte stays unchanged.
- R8: A sample presented in the same cycle as end of capture, or any cycle after it, is ignored until reset.
- R9: In reset and in the first cycle after it, byte valid, drained and pretrigger valid are low.
- R10: The record FIFO is never written while full, provided that samples which close records arrive no faster than the output drains them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_data_i | input | 16 | Sample word, all channels |
| smp_en_i | input | 1 | Sample enable, one sample per high cycle |
| trig_i | input | 1 | Marks the current sample as the trigger sample |
| cap_end_i | input | 1 | End-of-capture pulse |
| tx_byte_o | output | 8 | Output byte |
| tx_valid_o | output | 1 | Output byte valid |
| tx_ready_i | input | 1 | Downstream accepts the byte |
| pretrig_recs_o | output | TRIG_W | Records completed before the trigger sample |
| pretrig_valid_o | output | 1 | Pretrigger count is valid |
| drained_o | output | 1 | Capture flushed and every byte sent |

## Verification
The bench builds the block with three records per group, a four-entry FIFO and a 16-bit pretrigger counter. The small group size makes padding of one and of two records reachable with short captures. It also lets an 800-record capture pass 256 groups, so the sequence byte wraps from 255 to 0. The shallow FIFO, together with random ready stalls, keeps the queue near full, so the hold rule and the overflow property are exercised under real backpressure.

// File: rtl/rle_pkg.sv
// Shared definitions for the run-length packetizer.
// Assumes a fixed record layout: 16-bit sample value and 8-bit repeat count.
package rle_pkg;
    localparam int SMP_W   = 16;
    localparam int REP_W   = 8;
    localparam int REP_MAX = (1 << REP_W) - 1;

    // One run-length record; count sits in the low bits.
    typedef struct packed {
        logic [SMP_W-1:0] val;
        logic [REP_W-1:0] cnt;
    } rec_t;

    localparam int REC_W = $bits(rec_t);
endpackage

// File: rtl/rle_run_builder.sv
// Run builder: merges equal samples into records, splits runs at the count
// limit, breaks runs at the trigger sample, flushes and pads at end of capture.
// Assumes at most one record is needed per cycle while sampling; pad records
// wait for FIFO space.
module rle_run_builder
    import rle_pkg::*;
#(
    parameter int RECS_PER_GRP = 5,
    parameter int TRIG_W       = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SMP_W-1:0]  smp_data_i,
    input  logic              smp_en_i,
    input  logic              trig_i,
    input  logic              cap_end_i,
    input  logic              fifo_full_i,
    output logic              rec_push_o,
    output rec_t              rec_o,
    output logic [TRIG_W-1:0] pretrig_recs_o,
    output logic              pretrig_valid_o,
    output logic              flushed_o
);
    localparam int GW = (RECS_PER_GRP > 1) ? $clog2(RECS_PER_GRP) : 1;
    localparam logic [GW-1:0] GRP_LAST = GW'(RECS_PER_GRP - 1);

    typedef enum logic [1:0] {B_RUN, B_PAD, B_DONE} bstate_t;

    bstate_t          state_q;
    logic             have_q;
    logic [SMP_W-1:0] val_q;
    logic [REP_W-1:0] cnt_q;
    logic [SMP_W-1:0] last_q;
    logic [GW-1:0]    grp_q;
    logic [TRIG_W-1:0] total_q;
    logic             trig_seen_q;
    logic [TRIG_W-1:0] trig_recs_q;

    logic take;
    logic brk;

    // Decide whether this cycle emits a record and which one.
    always_comb begin
        take       = (state_q == B_RUN) && smp_en_i && !cap_end_i;
        brk        = have_q && (trig_i || (smp_data_i != val_q) || (cnt_q == REP_W'(REP_MAX)));
        rec_push_o = 1'b0;
        rec_o      = '{val: val_q, cnt: cnt_q};
        case (state_q)
            B_RUN: begin
                if (cap_end_i)  rec_push_o = have_q;
                else if (take)  rec_push_o = brk;
            end
            B_PAD: begin
                rec_o      = '{val: last_q, cnt: REP_W'(1)};
                rec_push_o = (grp_q != '0) && !fifo_full_i;
            end
            default: ;
        endcase
    end

    // Track the open run, group position, totals and the trigger count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= B_RUN;
            have_q      <= 1'b0;
            val_q       <= '0;
            cnt_q       <= '0;
            last_q      <= '0;
            grp_q       <= '0;
            total_q     <= '0;
            trig_seen_q <= 1'b0;
            trig_recs_q <= '0;
        end else begin
            if (rec_push_o) begin
                total_q <= total_q + TRIG_W'(1);
                grp_q   <= (grp_q == GRP_LAST) ? '0 : grp_q + GW'(1);
                last_q  <= rec_o.val;
            end
            case (state_q)
                B_RUN: begin
                    if (cap_end_i) begin
                        have_q  <= 1'b0;
                        state_q <= B_PAD;
                    end else if (take) begin
                        if (!have_q || brk) begin
                            val_q  <= smp_data_i;
                            cnt_q  <= REP_W'(1);
                            have_q <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + REP_W'(1);
                        end
                        if (trig_i && !trig_seen_q) begin
                            trig_seen_q <= 1'b1;
                            trig_recs_q <= total_q + (brk ? TRIG_W'(1) : TRIG_W'(0));
                        end
                    end
                end
                B_PAD: begin
                    if (grp_q == '0) state_q <= B_DONE;
                end
                default: ;
            endcase
        end
    end

    assign pretrig_recs_o  = trig_recs_q;
    assign pretrig_valid_o = trig_seen_q;
    assign flushed_o       = (state_q == B_DONE);
endmodule

// File: rtl/rle_rec_fifo.sv
// Record FIFO between run builder and byte serializer.
// Assumes DEPTH is a power of two; a write while full is dropped.
module rle_rec_fifo #(
    parameter int WIDTH = 24,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] dout_o,
    output logic             full_o,
    output logic             empty_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_q, rd_q;
    logic [AW:0]      cnt_q;
    logic             wr_ok, rd_ok;

    assign full_o  = (cnt_q == (AW+1)'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign wr_ok   = push_i && !full_o;
    assign rd_ok   = pop_i && !empty_o;
    assign dout_o  = mem[rd_q];

    // Store an accepted record.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_q] <= din_i;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_ok) wr_q <= wr_q + AW'(1);
            if (rd_ok) rd_q <= rd_q + AW'(1);
            case ({wr_ok, rd_ok})
                2'b10:   cnt_q <= cnt_q + (AW+1)'(1);
                2'b01:   cnt_q <= cnt_q - (AW+1)'(1);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rle_byte_serializer.sv
// Byte serializer: sends each record as three bytes, low value byte first,
// and appends a sequence byte after every RECS_PER_GRP records.
// Assumes the FIFO output is valid while not empty.
module rle_byte_serializer
    import rle_pkg::*;
#(
    parameter int RECS_PER_GRP = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_empty_i,
    input  rec_t       fifo_rec_i,
    output logic       fifo_pop_o,
    output logic [7:0] tx_byte_o,
    output logic       tx_valid_o,
    input  logic       tx_ready_i
);
    localparam int GW = (RECS_PER_GRP > 1) ? $clog2(RECS_PER_GRP) : 1;
    localparam logic [GW-1:0] GRP_LAST = GW'(RECS_PER_GRP - 1);

    logic          busy_q;
    logic [1:0]    phase_q;
    rec_t          rec_q;
    logic [GW-1:0] grp_q;
    logic [7:0]    seq_q;

    assign fifo_pop_o = !busy_q && !fifo_empty_i;
    assign tx_valid_o = busy_q;

    // Pick the byte for the current phase.
    always_comb begin
        case (phase_q)
            2'd0:    tx_byte_o = rec_q.val[7:0];
            2'd1:    tx_byte_o = rec_q.val[15:8];
            2'd2:    tx_byte_o = rec_q.cnt;
            default: tx_byte_o = seq_q;
        endcase
    end

    // Load records and step through bytes on each accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            phase_q <= 2'd0;
            rec_q   <= '0;
            grp_q   <= '0;
            seq_q   <= '0;
        end else if (fifo_pop_o) begin
            rec_q   <= fifo_rec_i;
            busy_q  <= 1'b1;
            phase_q <= 2'd0;
        end else if (busy_q && tx_ready_i) begin
            case (phase_q)
                2'd0: phase_q <= 2'd1;
                2'd1: phase_q <= 2'd2;
                2'd2: begin
                    if (grp_q == GRP_LAST) begin
                        grp_q   <= '0;
                        phase_q <= 2'd3;
                    end else begin
                        grp_q  <= grp_q + GW'(1);
                        busy_q <= 1'b0;
                    end
                end
                default: begin
                    seq_q  <= seq_q + 8'd1;
                    busy_q <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/rle_packetizer.sv
// Top of the run-length packetizer: run builder, record FIFO, byte serializer.
// Assumes record-closing samples arrive no faster than the output drains them.
module rle_packetizer
    import rle_pkg::*;
#(
    parameter int RECS_PER_GRP = 5,
    parameter int FIFO_DEPTH   = 4,
    parameter int TRIG_W       = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       smp_data_i,
    input  logic              smp_en_i,
    input  logic              trig_i,
    input  logic              cap_end_i,
    output logic [7:0]        tx_byte_o,
    output logic              tx_valid_o,
    input  logic              tx_ready_i,
    output logic [TRIG_W-1:0] pretrig_recs_o,
    output logic              pretrig_valid_o,
    output logic              drained_o
);
    logic rec_push;
    rec_t rec_data;
    rec_t fifo_rec;
    logic fifo_full, fifo_empty, fifo_pop;
    logic flushed;

    rle_run_builder #(.RECS_PER_GRP(RECS_PER_GRP), .TRIG_W(TRIG_W)) u_build (
        .clk(clk), .rst_n(rst_n),
        .smp_data_i(smp_data_i), .smp_en_i(smp_en_i),
        .trig_i(trig_i), .cap_end_i(cap_end_i),
        .fifo_full_i(fifo_full),
        .rec_push_o(rec_push), .rec_o(rec_data),
        .pretrig_recs_o(pretrig_recs_o), .pretrig_valid_o(pretrig_valid_o),
        .flushed_o(flushed)
    );

    rle_rec_fifo #(.WIDTH(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(rec_push), .din_i(rec_data),
        .pop_i(fifo_pop), .dout_o(fifo_rec),
        .full_o(fifo_full), .empty_o(fifo_empty)
    );

    rle_byte_serializer #(.RECS_PER_GRP(RECS_PER_GRP)) u_ser (
        .clk(clk), .rst_n(rst_n),
        .fifo_empty_i(fifo_empty), .fifo_rec_i(fifo_rec),
        .fifo_pop_o(fifo_pop),
        .tx_byte_o(tx_byte_o), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i)
    );

    // Drained once the builder is done and nothing is queued or in flight.
    assign drained_o = flushed && fifo_empty && !tx_valid_o;
endmodule

// File: rtl/rle_packetizer_chk.sv
// Property checker for the packetizer, attached by bind.
module rle_packetizer_chk #(
    parameter int TRIG_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        tx_byte,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              push,
    input logic              full,
    input logic [7:0]        push_cnt,
    input logic [TRIG_W-1:0] pretrig_recs,
    input logic              pretrig_valid,
    input logic              drained
);
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    assert_cnt_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (push_cnt != 8'd0));

    assert_pretrig_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pretrig_valid |=> (pretrig_valid && $stable(pretrig_recs)));

    assert_drained_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drained |-> (!tx_valid && !push));

    assert_drained_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drained |=> drained);

    assert_reset_R9: assert property (@(posedge clk)
        !rst_n |=> (!tx_valid && !drained && !pretrig_valid));
endmodule

bind rle_packetizer rle_packetizer_chk #(.TRIG_W(TRIG_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .tx_byte(tx_byte_o), .tx_valid(tx_valid_o), .tx_ready(tx_ready_i),
    .push(rec_push), .full(fifo_full), .push_cnt(rec_data.cnt),
    .pretrig_recs(pretrig_recs_o), .pretrig_valid(pretrig_valid_o),
    .drained(drained_o)
);

// File: tb/tb_rle_packetizer.sv
module tb_rle_packetizer;
    localparam int CLK_PERIOD = 10;
    localparam int GRP        = 3;
    localparam int TW         = 16;
    localparam int NSEG       = 9;
    // Segment table: [31:16] value, [15:4] run length, [0] trigger on first sample.
    // Expected records: 1234x5, ABCDx255, 0F0Fx100, 0F0Fx50 (trigger), 0001x255,
    // 0001x1, FFFFx1, 8000x255, 8000x255, 8000x10 -> 10 records, pretrigger 3.
    localparam logic [31:0] SEGS [NSEG] = '{
        {16'h1234, 12'd3,   4'h0},
        {16'h1234, 12'd2,   4'h0},
        {16'hABCD, 12'd255, 4'h0},
        {16'h0F0F, 12'd100, 4'h0},
        {16'h0F0F, 12'd50,  4'h1},
        {16'h0001, 12'd256, 4'h0},
        {16'hFFFF, 12'd1,   4'h0},
        {16'h8000, 12'd500, 4'h0},
        {16'h8000, 12'd20,  4'h0}
    };

    logic          clk = 0;
    logic          rst_n = 0;
    logic [15:0]   smp = '0;
    logic          smp_en = 0, trig = 0, cap_end = 0;
    logic [7:0]    tx_byte;
    logic          tx_valid;
    logic          tx_ready = 1;
    logic [TW-1:0] pre_recs;
    logic          pre_valid, drained;

    int checks = 0, errors = 0, cyc = 0;
    logic [7:0]  got[$];
    logic [23:0] mrecs[$];
    logic [7:0]  exp_b[$];
    logic        m_have;
    logic [15:0] m_val;
    int          m_cnt, m_trig;
    logic        bp_en = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic        stall_q = 0;
    logic [7:0]  stall_b = 0;
    int          hold_err = 0;

    rle_packetizer #(.RECS_PER_GRP(GRP), .FIFO_DEPTH(4), .TRIG_W(TW)) dut (
        .clk(clk), .rst_n(rst_n), .smp_data_i(smp), .smp_en_i(smp_en),
        .trig_i(trig), .cap_end_i(cap_end), .tx_byte_o(tx_byte),
        .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
        .pretrig_recs_o(pre_recs), .pretrig_valid_o(pre_valid), .drained_o(drained)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Output side: choose ready, then collect accepted bytes and watch holds.
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_ready = bp_en ? (lfsr[1:0] != 2'b00) : 1'b1;
        if (rst_n) begin
            if (stall_q && (!tx_valid || tx_byte != stall_b)) hold_err++;
            if (tx_valid && tx_ready) got.push_back(tx_byte);
            stall_q = tx_valid && !tx_ready;
            stall_b = tx_byte;
        end else begin
            stall_q = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; smp_en = 0; trig = 0; cap_end = 0;
        repeat (3) @(negedge clk);
        got.delete(); mrecs.delete(); exp_b.delete();
        m_have = 0; m_val = 0; m_cnt = 0; m_trig = -1; hold_err = 0;
        rst_n = 1;
    endtask

    // Reference model of one accepted sample, from R2, R3, R4.
    task automatic m_sample(input logic [15:0] v, input logic t);
        if (m_have && (t || v != m_val || m_cnt == 255)) begin
            mrecs.push_back({m_val, 8'(m_cnt)});
            m_have = 0;
        end
        if (t && m_trig < 0) m_trig = mrecs.size();
        if (!m_have) begin m_val = v; m_cnt = 1; m_have = 1; end
        else m_cnt++;
    endtask

    // Reference model of end of capture and serialization, from R1, R5, R6.
    task automatic m_finish();
        if (m_have) mrecs.push_back({m_val, 8'(m_cnt)});
        while (mrecs.size() % GRP != 0) mrecs.push_back({mrecs[$][23:8], 8'd1});
        for (int i = 0; i < mrecs.size(); i++) begin
            exp_b.push_back(mrecs[i][15:8]);
            exp_b.push_back(mrecs[i][23:16]);
            exp_b.push_back(mrecs[i][7:0]);
            if ((i + 1) % GRP == 0) exp_b.push_back(8'((i / GRP) % 256));
        end
    endtask

    task automatic send(input logic [15:0] v, input logic t, input int gap);
        @(negedge clk);
        smp = v; smp_en = 1; trig = t;
        m_sample(v, t);
        @(negedge clk);
        smp_en = 0; trig = 0;
        repeat (gap - 1) @(negedge clk);
    endtask

    task automatic end_capture(input logic with_smp, input logic [15:0] v);
        @(negedge clk);
        cap_end = 1; smp_en = with_smp; smp = v;
        @(negedge clk);
        cap_end = 0; smp_en = 0;
        m_finish();
    endtask

    task automatic wait_drained(input string tag);
        int n = 0;
        while (!drained && n < 20000) begin @(negedge clk); n++; end
        chk(drained, tag, "drained flag", drained, 1);
        repeat (2) @(negedge clk);
    endtask

    task automatic compare_stream(input string tag);
        chk(got.size() == exp_b.size(), "R6", {tag, " byte count"}, got.size(), exp_b.size());
        for (int i = 0; i < got.size() && i < exp_b.size(); i++) begin
            bit ok = (got[i] == exp_b[i]);
            bit is_seq = ((i % (3 * GRP + 1)) == 3 * GRP);
            chk(ok, is_seq ? "R5" : "R1", {tag, " stream byte"}, got[i], exp_b[i]);
            if (!ok) break;
        end
        chk(hold_err == 0, "R7", {tag, " hold violations"}, hold_err, 0);
    endtask

    initial begin
        // Reset state, R9.
        do_reset();
        chk(!tx_valid, "R9", "valid after reset", tx_valid, 0);
        chk(!drained, "R9", "drained after reset", drained, 0);
        chk(!pre_valid, "R9", "pretrigger valid after reset", pre_valid, 0);

        // Table walk: merging, splitting, trigger mid-run, padding of two (R2 R3 R4 R6).
        bp_en = 1;
        for (int s = 0; s < NSEG; s++) begin
            for (int k = 0; k < int'(SEGS[s][15:4]); k++)
                send(SEGS[s][31:16], (k == 0) && SEGS[s][0], 3);
        end
        end_capture(0, 16'h0);
        wait_drained("R6");
        chk(pre_valid, "R4", "pretrigger valid", pre_valid, 1);
        chk(pre_recs == 3, "R4", "pretrigger count", pre_recs, 3);
        chk(exp_b.size() == 40, "R3", "model record split total", exp_b.size(), 40);
        compare_stream("table");

        // Sequence wrap: 800 one-sample records, second trigger ignored (R5 R4).
        do_reset();
        for (int i = 0; i < 800; i++)
            send((i % 2) ? 16'hAAAA : 16'h5555, (i == 10) || (i == 20), 8);
        end_capture(0, 16'h0);
        wait_drained("R6");
        chk(pre_recs == 10, "R4", "first trigger kept", pre_recs, 10);
        chk(got.size() == 2670, "R5", "wrap stream length", got.size(), 2670);
        if (got.size() == 2670)
            chk(got[2669] == 8'd10, "R5", "seq byte after wrap", got[2669], 10);
        compare_stream("wrap");

        // Empty capture produces nothing (R6).
        do_reset();
        end_capture(0, 16'h0);
        wait_drained("R6");
        chk(got.size() == 0, "R6", "empty capture bytes", got.size(), 0);
        chk(!pre_valid, "R4", "no trigger no count", pre_valid, 0);

        // Trigger on first sample, sample with and after end ignored (R4 R8 R6).
        do_reset();
        bp_en = 0;
        send(16'h0042, 1, 3);
        send(16'h0042, 0, 3);
        end_capture(1, 16'h0099);
        send(16'h0077, 0, 2);
        send(16'h0077, 1, 2);
        wait_drained("R6");
        chk(pre_recs == 0, "R4", "trigger on first sample", pre_recs, 0);
        chk(got.size() == 10, "R8", "late samples ignored, length", got.size(), 10);
        if (got.size() == 10) begin
            chk(got[2] == 8'd2, "R8", "flushed run count", got[2], 2);
            chk(got[3] == 8'h42 && got[5] == 8'd1, "R6", "pad record", {got[3], got[5]}, 16'h4201);
            chk(got[9] == 8'd0, "R5", "first seq byte", got[9], 0);
        end
        compare_stream("end");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule